// File: doc/BRIEF.md
# Wait-State Bus Target with Burst Reads

This block is a memory-mapped target on a simple synchronous processor bus. A master starts a transfer by raising an address strobe for one sampled edge, together with a direction line (high for read, low for write) and a word address. The target answers with an active-low ready line. While ready is low, the read data port carries the addressed word. Before each ready pulse the target can hold ready high for a fixed number of extra cycles, so that slow storage can be modelled with the same bus.

A read that starts with the burst line high streams words from consecutive addresses, one word per ready pulse. The addresses wrap at the end of the array. The master ends the stream by dropping the burst line. The target samples that line only on the edge that closes a ready pulse, so one more word follows the pulse during which the line was seen low. Writes always move a single word. The storage is a small register array inside the block.

Top module: `wsbus_target`

## Requirements
- R1: After reset, ready_n is high, rdata is zero and every word of the array reads as zero.
- R2: A transfer starts on a rising edge where addr_en is high while the target is idle. rd_nwr (1 = read, 0 = write) and addr are captured on that edge. addr_en and addr are ignored until the transfer ends. rd_nwr must stay constant from the start edge until the transfer ends.
- R3: With WAITS = 0, ready_n is low in the cycle that follows the start edge, and rdata holds the word at the captured address.
- R4: With WAITS = N > 0, ready_n stays high for exactly N cycles after the start edge and after each burst pulse, and is then low for the next beat.
- R5: ready_n is low for exactly one cycle per beat. rdata is zero in every cycle where ready_n is high.
- R6: For a write, the wdata value present on the edge that drives ready_n low is stored at the captured address. Later reads of that address return it.
- R7: In a burst read, beat k returns the word at (start address + k) modulo the array depth.
- R8: burst is sampled at the start edge and on each edge that ends a beat. The beat that follows the first such sample that is low is the last beat. A read that starts with burst low delivers one beat.
- R9: A write that starts with burst high still delivers exactly one beat and changes only the addressed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_en | input | 1 | Address strobe; starts a transfer when sampled high while idle |
| rd_nwr | input | 1 | Direction: 1 = read, 0 = write |
| addr | input | AW | Word address |
| burst | input | 1 | Burst continue request for reads |
| wdata | input | DW | Write data, held by the master until the beat |
| rdata | output | DW | Read data, valid while rdy_n is low, zero otherwise |
| rdy_n | output | 1 | Active-low data-ready acknowledge |

## Verification
The bench drives three copies of the block, with 0, 1 and 3 wait states, over every address with single reads and writes. It times the gap between the start edge and each beat, so an off-by-one wait counter shows up as a latency error. Bursts of one to six words, some of them crossing the top of the array, check the point at which the target stops. A target that reacted to the burst line at once would lose the trailing word, and one that failed to wrap would return the wrong words. Other runs keep the strobe high and move the address while a transfer is in flight, or start a write with the burst line raised. A target that restarted, latched late, or streamed writes would add extra beats or corrupt the neighbouring word.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BEAT = 2'd2
    } bus_state_e;

endpackage

// File: rtl/wsbus_wait_ctr.sv
module wsbus_wait_ctr #(
    parameter int WAITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic last
);
    localparam int CW = (WAITS > 0) ? $clog2(WAITS + 1) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WAITS);
        end else if (step && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (WAITS == 0) ? 1'b1 : (cnt_q == CW'(1));

    // R4: the remaining wait count never exceeds the configured number
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= WAITS);

endmodule

// File: rtl/wsbus_store.sv
module wsbus_store #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] word_d [DEPTH];
    logic [DW-1:0] word_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_comb begin
            word_d[i] = word_q[i];
            if (we && waddr == AW'(i)) word_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[i] <= '0;
            else        word_q[i] <= word_d[i];
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/wsbus_target.sv
module wsbus_target
    import wsbus_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 16,
    parameter int WAITS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_en,
    input  logic          rd_nwr,
    input  logic [AW-1:0] addr,
    input  logic          burst,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdy_n
);
    typedef struct packed {
        bus_state_e    st;
        logic [AW-1:0] ad;
        logic          rd;
        logic          more;
        logic          rdy_n;
        logic [DW-1:0] rdata;
    } tgt_regs_t;

    tgt_regs_t     r_d, r_q;
    logic          ctr_load, ctr_step, ctr_last;
    logic          go_beat, beat_rd, we;
    logic [AW-1:0] beat_addr;
    logic [DW-1:0] mem_word;

    wsbus_wait_ctr #(.WAITS(WAITS)) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ctr_load),
        .step (ctr_step),
        .last (ctr_last)
    );

    wsbus_store #(.AW(AW), .DW(DW)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(beat_addr),
        .wdata(wdata),
        .raddr(beat_addr),
        .rdata(mem_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rdy_n = 1'b1;
        r_d.rdata = '0;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        go_beat  = 1'b0;
        we       = 1'b0;

        unique case (r_q.st)
            ST_IDLE: beat_addr = addr;
            ST_BEAT: beat_addr = r_q.ad + 1'b1;
            default: beat_addr = r_q.ad;
        endcase
        beat_rd = (r_q.st == ST_IDLE) ? rd_nwr : r_q.rd;

        unique case (r_q.st)
            ST_IDLE: begin
                if (addr_en) begin
                    r_d.ad   = addr;
                    r_d.rd   = rd_nwr;
                    r_d.more = burst & rd_nwr;
                    if (WAITS == 0) begin
                        go_beat = 1'b1;
                    end else begin
                        r_d.st   = ST_WAIT;
                        ctr_load = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                ctr_step = 1'b1;
                if (ctr_last) go_beat = 1'b1;
            end
            ST_BEAT: begin
                if (r_q.more) begin
                    r_d.ad   = beat_addr;
                    r_d.more = burst;
                    if (WAITS == 0) begin
                        go_beat = 1'b1;
                    end else begin
                        r_d.st   = ST_WAIT;
                        ctr_load = 1'b1;
                    end
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (go_beat) begin
            r_d.st    = ST_BEAT;
            r_d.rdy_n = 1'b0;
            if (beat_rd) r_d.rdata = mem_word;
            else         we = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ad: '0, rd: 1'b1, more: 1'b0,
                     rdy_n: 1'b1, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rdy_n = r_q.rdy_n;
    assign rdata = r_q.rdata;

    if (WAITS == 0) begin : g_nowait_chk
        // R3: acknowledge follows the start edge directly
        a_r3_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.st == ST_IDLE && addr_en) |=> !rdy_n);
    end else begin : g_wait_chk
        // R4: the first cycle after a start is a wait cycle
        a_r4_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.st == ST_IDLE && addr_en) |=> rdy_n);
        // R5: with wait states every beat is a single-cycle pulse
        a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            !rdy_n |=> rdy_n);
    end

    // R8: a beat with no pending continuation is the last one
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !r_q.more) |=> rdy_n);

    // R9: a write never arms a burst continuation
    a_r9_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && addr_en && !rd_nwr) |=> !r_q.more);

    // R2: the master keeps the direction fixed during a transfer
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> $stable(rd_nwr));

endmodule

// File: tb/wsbus_target_test.sv
module wsbus_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 3;
    localparam int WS [NCFG] = '{0, 1, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_en = 1'b0;
    logic        rd_nwr = 1'b1;
    logic [3:0]  addr = '0;
    logic        burst = 1'b0;
    logic [15:0] wdata = '0;
    int          sel = 0;
    logic        rdy_n_v [NCFG];
    logic [15:0] rdata_v [NCFG];
    logic [15:0] refm [NCFG][16];
    int          nchk = 0;
    int          nerr = 0;
    int          cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
        wsbus_target #(.AW(4), .DW(16), .WAITS(WS[i])) uut (
            .clk    (clk),
            .rst_n  (rst_n),
            .addr_en(addr_en && (sel == i)),
            .rd_nwr (rd_nwr),
            .addr   (addr),
            .burst  (burst),
            .wdata  (wdata),
            .rdata  (rdata_v[i]),
            .rdy_n  (rdy_n_v[i])
        );
    end

    function automatic logic [15:0] wpat(input int c, input int a, input int seed);
        return 16'((c + 1) * 4099 + a * 771 + seed * 13 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transfer on configuration c; checks latency, data, idle rdata and beat count
    task automatic run_txn(input int c, input bit rd, input int a, input int blen,
                           input bit hold, input int seed, input string tag);
        int exp_beats = rd ? blen : 1;
        int beats = 0;
        int cyc = 0;
        int last_cyc = 0;
        int w = WS[c];
        logic [15:0] wd = wpat(c, a, seed);
        string lat_tag = (w == 0) ? "R3 latency" : "R4 latency";
        @(negedge clk);
        sel = c; addr_en = 1'b1; rd_nwr = rd; addr = a[3:0];
        wdata = wd; burst = (blen > 1);
        while (cyc - last_cyc <= w + 2) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                addr_en = hold;
                if (hold) addr = ~a[3:0];
            end
            if (!rdy_n_v[c]) begin
                chk(cyc - last_cyc == w + 1, lat_tag, cyc - last_cyc, w + 1);
                if (rd) begin
                    chk(rdata_v[c] == refm[c][(a + beats) % 16], tag,
                        rdata_v[c], refm[c][(a + beats) % 16]);
                end else begin
                    refm[c][a] = wd;
                end
                beats++;
                last_cyc = cyc;
                if (hold) addr_en = 1'b0;
                if (beats == blen - 1) burst = 1'b0;
            end else begin
                chk(rdata_v[c] == '0, "R5 idle rdata", rdata_v[c], 0);
            end
        end
        chk(beats == exp_beats, rd ? "R8 beat count" : "R9 write beats", beats, exp_beats);
        addr_en = 1'b0; rd_nwr = 1'b1; burst = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                nerr++;
                nchk++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        end
    end

    initial begin
        for (int c = 0; c < NCFG; c++)
            for (int a = 0; a < 16; a++) refm[c][a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NCFG; c++) begin
            chk(rdy_n_v[c] == 1'b1, "R1 reset rdy_n", rdy_n_v[c], 1);
            chk(rdata_v[c] == '0, "R1 reset rdata", rdata_v[c], 0);
        end

        for (int c = 0; c < NCFG; c++) begin
            // R1: array is zero after reset
            for (int a = 0; a < 16; a++) run_txn(c, 1'b1, a, 1, 1'b0, 0, "R1 reset word");
            // R6 writes, some holding the strobe and moving addr (R2)
            for (int a = 0; a < 16; a++) run_txn(c, 1'b0, a, 1, (a % 4) == 0, 1, "R6 write");
            for (int a = 0; a < 16; a++) run_txn(c, 1'b1, a, 1, (a % 3) == 0, 0, "R2 R6 readback");
            // R9: write with burst raised touches only one word
            run_txn(c, 1'b0, 5, 4, 1'b0, 2, "R9 write");
            run_txn(c, 1'b1, 5, 1, 1'b0, 0, "R9 target word");
            run_txn(c, 1'b1, 6, 1, 1'b0, 0, "R9 neighbour word");
            // R7/R8: bursts of several lengths, some wrapping
            for (int len = 1; len <= 6; len++)
                run_txn(c, 1'b1, (len * 5 + 3) % 16, len, 1'b0, 0, "R7 burst data");
            run_txn(c, 1'b1, 14, 6, 1'b0, 0, "R7 wrap burst");
            for (int a = 0; a < 16; a += 2) run_txn(c, 1'b0, a, 1, 1'b0, 3, "R6 rewrite");
            run_txn(c, 1'b1, 9, 16, 1'b1, 0, "R7 full burst");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule